// File: doc/BRIEF.md
# Dual-Mode Converter Serial Port

This block is the device-side serial port of a multi-channel converter. A host reaches it through an active-low chip select, a frame sync, a clock-inversion select, a serial clock and a serial data input. The block samples all of these with its own, faster system clock. When chip select falls, the block records the frame sync level as the host type: a microprocessor-style host or a DSP-style host. The host type and the inversion select together decide which serial clock edge captures the 4-bit channel address. They also decide which edge shifts out the previous 10-bit result, and which edges open and close the analog sample window.

The tenth closing edge of a frame pulls end-of-conversion low and sends a one-cycle start pulse to the converter core. When the core reports completion, it loads a new result into the port's holding register, and that result is read out during the next frame. The serial data output is modelled as a data bit plus an output enable, which stands in for the high-impedance state.

The serial clock must run at no more than a quarter of the system clock rate. Chip select, frame sync, serial clock, data in and the inversion select each pass through a two-stage synchronizer. Outputs therefore follow a serial edge after about three system clocks.

Top module: `adc_serial_port`

## Requirements
- R1: While chip select is high, the output enable is 0. Serial clock and data-in activity then changes neither the window, the address, the address-valid flag, end-of-conversion nor the start pulse.
- R2: On the falling edge of chip select, the host type is latched from frame sync: high selects microprocessor (MCU) mode and low selects DSP mode. Later frame sync changes within the frame do not alter the mode.
- R3: In MCU mode, the output enable rises and the result MSB is driven as soon as chip select falls. In DSP mode, the output enable stays 0 and no serial edge counts until frame sync falls while chip select is low. At that point the MSB is driven.
- R4: The address capture edge is the rising edge when the mode bit equals the inversion select, and the falling edge otherwise. The first four capture edges shift data in, MSB first. The address-valid flag is 0 from chip select fall until the fourth capture edge, and the address output changes only at that edge.
- R5: Output shift edges are falling in MCU mode and rising in DSP mode, whatever the inversion select. Each of the first nine shift edges moves the output to the next lower bit of the 10-bit result.
- R6: The sample window opens on the fourth shift-type edge and closes on the tenth edge of the opposite polarity. That is fourth falling to tenth rising in MCU mode, and fourth rising to tenth falling in DSP mode.
- R7: The tenth closing edge gives exactly one start pulse of one system clock and drives end-of-conversion low.
- R8: Serial clocks 11 to 16 of a frame give no further start pulse, leave the window closed and leave the output on the LSB.
- R9: A conversion-done pulse loads the result input into the holding register and sets end-of-conversion high. A frame reads out the value held when it started, even if a load arrives mid-frame.
- R10: After reset, the output enable, window, address-valid and start pulse are 0, the address is 0, end-of-conversion is 1 and the holding register is 0.
- R11: A frame with fewer than ten clocks gives no start pulse and leaves end-of-conversion unchanged. Raising chip select closes a still-open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| fs | input | 1 | Frame sync from the host |
| edge_inv | input | 1 | Clock-inversion select for address capture |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial address data in |
| conv_done | input | 1 | Converter core finished, load result |
| conv_result | input | 10 | New conversion result |
| sdo | output | 1 | Serial result data out (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for sdo |
| chan_addr | output | 4 | Captured channel address |
| chan_valid | output | 1 | Address captured in this frame |
| sample_win | output | 1 | Analog sample window |
| eoc | output | 1 | End-of-conversion flag |
| conv_start | output | 1 | One-cycle conversion start pulse |

## Verification
The bench runs all four combinations of host type and inversion select. It tracks rising and falling serial edges separately and compares every output after each edge. A design that swaps capture polarity loads the wrong address, and one that lets the inversion select steer output timing shifts the result on the wrong edge. Frames of 12 and 16 clocks catch a counter that wraps and fires a second start pulse or reopens the window. A result loaded in the middle of a frame catches a shifter that reloads from the holding register. A six-clock frame and serial activity with chip select high catch a design that starts conversion early or counts while deselected. Driving frame sync while in MCU mode, and pulsing it in DSP mode, catches a mode flag that does not stay latched.

// File: rtl/asp_pkg.sv
// Shared types for the converter serial port.
package asp_pkg;
    // Host type, latched at each chip-select fall.
    typedef enum logic {
        HOST_DSP = 1'b0,
        HOST_MCU = 1'b1
    } host_mode_e;

    // Serial clock events after polarity routing.
    typedef struct packed {
        logic cap;    // address capture edge
        logic open;   // output shift and window-open edge
        logic close;  // window-close and conversion-start edge
    } sclk_ev_t;
endpackage

// File: rtl/asp_sync.sv
// Multi-bit level synchronizer.
// Each bit runs through STAGES flops clocked by the system clock.
// Assumes the inputs are level signals changing slower than the system clock.
module asp_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], din};
    end

    assign lvl = stg[STAGES-1];
endmodule

// File: rtl/asp_edge_route.sv
// Maps serial clock rising/falling events onto the roles the port needs.
// Capture uses the rising edge when the mode bit equals the inversion select.
// Shift/open and close depend on the host type only.
// Purely combinational.
module asp_edge_route
    import asp_pkg::*;
(
    input  host_mode_e mode,
    input  logic       inv_lvl,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    output sclk_ev_t   ev
);
    logic is_mcu;
    assign is_mcu = (mode == HOST_MCU);

    // Select the edge for each role from the host type and inversion select.
    always_comb begin
        ev.cap   = (is_mcu == inv_lvl) ? sclk_rise : sclk_fall;
        ev.open  = is_mcu ? sclk_fall : sclk_rise;
        ev.close = is_mcu ? sclk_rise : sclk_fall;
    end
endmodule

// File: rtl/asp_frame_ctrl.sv
// Frame sequencer.
// Detects edges on the synchronized chip select, frame sync and serial clock.
// Latches the host type and arms the frame.
// Counts routed serial edges, captures the channel address and drives the
// sample window, end-of-conversion and the start pulse.
// Assumes synchronized inputs and at least two system clocks per serial half period.
module asp_frame_ctrl
    import asp_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 10,
    parameter int WIN_OPEN  = 4,
    parameter int WIN_CLOSE = 10,
    parameter int MAX_CLKS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              fs_lvl,
    input  logic              inv_lvl,
    input  logic              sclk_lvl,
    input  logic              sdi_lvl,
    input  logic              conv_done,
    output logic              frame_load,
    output logic              armed,
    output logic              shift_adv,
    output logic [ADDR_W-1:0] chan_addr,
    output logic              chan_valid,
    output logic              sample_win,
    output logic              eoc,
    output logic              conv_start
);
    localparam int               CNT_W    = $clog2(MAX_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_CLKS);
    localparam logic [CNT_W-1:0] OPEN_AT  = CNT_W'(WIN_OPEN - 1);
    localparam logic [CNT_W-1:0] CLOSE_AT = CNT_W'(WIN_CLOSE - 1);
    localparam logic [CNT_W-1:0] ADDR_AT  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] ADDR_CNT = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] SHIFT_N  = CNT_W'(DATA_W - 1);

    logic       cs_q, fs_q, sclk_q;
    logic       cs_fall, fs_fall, sclk_rise, sclk_fall;
    host_mode_e mode;
    sclk_ev_t   ev;
    logic       live, cap_hit, open_hit, close_hit;
    logic [CNT_W-1:0]  cnt_cap, cnt_open, cnt_close;
    logic [ADDR_W-1:0] addr_sh;

    // Keep previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            fs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_lvl;
            fs_q   <= fs_lvl;
            sclk_q <= sclk_lvl;
        end
    end

    assign cs_fall   = cs_q & ~cs_lvl;
    assign fs_fall   = fs_q & ~fs_lvl;
    assign sclk_rise = ~sclk_q & sclk_lvl;
    assign sclk_fall = sclk_q & ~sclk_lvl;

    asp_edge_route u_route (
        .mode      (mode),
        .inv_lvl   (inv_lvl),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .ev        (ev)
    );

    assign live       = armed & ~cs_lvl;
    assign cap_hit    = live & ev.cap;
    assign open_hit   = live & ev.open;
    assign close_hit  = live & ev.close;
    assign frame_load = cs_fall;
    assign shift_adv  = open_hit & (cnt_open < SHIFT_N);

    // Latch the host type at chip-select fall and arm the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= HOST_MCU;
            armed <= 1'b0;
        end else if (cs_lvl) begin
            armed <= 1'b0;
        end else if (cs_fall) begin
            mode  <= fs_lvl ? HOST_MCU : HOST_DSP;
            armed <= fs_lvl;
        end else if (mode == HOST_DSP && fs_fall) begin
            armed <= 1'b1;
        end
    end

    // Count each routed edge role, saturating at the frame limit.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall) begin
            cnt_cap   <= '0;
            cnt_open  <= '0;
            cnt_close <= '0;
        end else begin
            if (cap_hit && cnt_cap < CNT_MAX)     cnt_cap   <= cnt_cap + 1'b1;
            if (open_hit && cnt_open < CNT_MAX)   cnt_open  <= cnt_open + 1'b1;
            if (close_hit && cnt_close < CNT_MAX) cnt_close <= cnt_close + 1'b1;
        end
    end

    // Shift in the channel address and publish it on the last capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_sh    <= '0;
            chan_addr  <= '0;
            chan_valid <= 1'b0;
        end else if (cs_fall) begin
            chan_valid <= 1'b0;
        end else if (cap_hit && cnt_cap < ADDR_CNT) begin
            addr_sh <= {addr_sh[ADDR_W-2:0], sdi_lvl};
            if (cnt_cap == ADDR_AT) begin
                chan_addr  <= {addr_sh[ADDR_W-2:0], sdi_lvl};
                chan_valid <= 1'b1;
            end
        end
    end

    // Open and close the sample window.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_lvl || cs_fall) begin
            sample_win <= 1'b0;
        end else begin
            if (open_hit && cnt_open == OPEN_AT)    sample_win <= 1'b1;
            if (close_hit && cnt_close == CLOSE_AT) sample_win <= 1'b0;
        end
    end

    // Issue the start pulse and track end-of-conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            eoc        <= 1'b1;
        end else begin
            conv_start <= close_hit && cnt_close == CLOSE_AT;
            if (close_hit && cnt_close == CLOSE_AT) eoc <= 1'b0;
            else if (conv_done)                     eoc <= 1'b1;
        end
    end

    // R7
    start_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(sample_win));

    // R7
    start_eoc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !eoc);

    // R8
    close_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_close <= CNT_MAX && cnt_open <= CNT_MAX);

    // R4
    addr_valid_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_valid) |-> cnt_cap == ADDR_CNT);

    // R2
    mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(mode));
endmodule

// File: rtl/asp_out_shift.sv
// Result holding register and serial output shifter.
// The holding register loads on conversion-done.
// The shifter copies the holding register at frame start and steps once per
// shift advance, MSB first.
// Assumes shift_adv is already limited to the first DATA_W-1 shift edges.
module asp_out_shift #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              frame_load,
    input  logic              shift_adv,
    input  logic              out_en,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [DATA_W-1:0] hold_q, shreg;

    // Capture a finished conversion result.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (conv_done) hold_q <= conv_result;
    end

    // Load at frame start, then shift toward the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n)          shreg <= '0;
        else if (frame_load) shreg <= hold_q;
        else if (shift_adv)  shreg <= {shreg[DATA_W-2:0], 1'b0};
    end

    assign sdo_oe = out_en;
    assign sdo    = out_en & shreg[DATA_W-1];

    // R5
    no_shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_adv |-> out_en);
endmodule

// File: rtl/adc_serial_port.sv
// Top of the dual-mode converter serial port.
// Synchronizes the host pins, sequences each frame and shifts out the
// previous result.
// Assumes the serial clock runs at no more than a quarter of clk.
module adc_serial_port #(
    parameter int DATA_W      = 10,
    parameter int ADDR_W      = 4,
    parameter int WIN_OPEN    = 4,
    parameter int WIN_CLOSE   = 10,
    parameter int MAX_CLKS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              fs,
    input  logic              edge_inv,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [ADDR_W-1:0] chan_addr,
    output logic              chan_valid,
    output logic              sample_win,
    output logic              eoc,
    output logic              conv_start
);
    localparam int PIN_N = 5;

    logic [PIN_N-1:0] pins_lvl;
    logic             frame_load, armed, shift_adv;

    // Bit order: cs_n, fs, sclk, sdi, edge_inv (LSB first).
    asp_sync #(
        .W       (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b00011)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({edge_inv, sdi, sclk, fs, cs_n}),
        .lvl   (pins_lvl)
    );

    asp_frame_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .WIN_OPEN  (WIN_OPEN),
        .WIN_CLOSE (WIN_CLOSE),
        .MAX_CLKS  (MAX_CLKS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_lvl     (pins_lvl[0]),
        .fs_lvl     (pins_lvl[1]),
        .sclk_lvl   (pins_lvl[2]),
        .sdi_lvl    (pins_lvl[3]),
        .inv_lvl    (pins_lvl[4]),
        .conv_done  (conv_done),
        .frame_load (frame_load),
        .armed      (armed),
        .shift_adv  (shift_adv),
        .chan_addr  (chan_addr),
        .chan_valid (chan_valid),
        .sample_win (sample_win),
        .eoc        (eoc),
        .conv_start (conv_start)
    );

    asp_out_shift #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .frame_load  (frame_load),
        .shift_adv   (shift_adv),
        .out_en      (armed),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe)
    );

    // R1
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_lvl[0] && $past(pins_lvl[0])) |-> !sdo_oe);

    // R1
    idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_lvl[0] && $past(pins_lvl[0])) |-> !conv_start);
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, fs = 1'b1, edge_inv = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic       sdo, sdo_oe, chan_valid, sample_win, eoc, conv_start;
    logic [3:0] chan_addr;

    int   n_chk = 0, n_bad = 0, conv_cnt = 0;
    bit   done = 1'b0;
    logic [9:0] res_model = '0;
    logic       eoc_model = 1'b1;

    always #4 clk = ~clk;

    adc_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .edge_inv(edge_inv),
        .sclk(sclk), .sdi(sdi), .conv_done(conv_done), .conv_result(conv_result),
        .sdo(sdo), .sdo_oe(sdo_oe), .chan_addr(chan_addr), .chan_valid(chan_valid),
        .sample_win(sample_win), .eoc(eoc), .conv_start(conv_start)
    );

    // Count start pulses away from the active edge.
    always @(negedge clk) if (rst_n && conv_start) conv_cnt++;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic t_reset();
        // R10
        chk("R10", "sdo_oe", sdo_oe, 0);
        chk("R10", "eoc", eoc, 1);
        chk("R10", "sample_win", sample_win, 0);
        chk("R10", "chan_valid", chan_valid, 0);
        chk("R10", "chan_addr", chan_addr, 0);
        chk("R10", "conv_start", conv_start, 0);
    endtask

    task automatic t_load(input logic [9:0] v);
        conv_result = v;
        conv_done = 1'b1;
        wait_clk(1);
        conv_done = 1'b0;
        res_model = v;
        eoc_model = 1'b1;
        wait_clk(4);
        // R9
        chk("R9", "eoc after load", eoc, 1);
    endtask

    task automatic check_state(input bit mp, input bit inv, input logic [3:0] addr,
                               input logic [9:0] data, input int nr, input int nf,
                               input int starts, input bit late_load);
        int opn, cls, cap, sh;
        string rq;
        opn = mp ? nf : nr;
        cls = mp ? nr : nf;
        cap = (mp == inv) ? nr : nf;
        sh  = mp ? nf : nr;
        if (cls >= 10) eoc_model = 1'b0;
        rq = (cls > 10) ? "R8" : "R6";
        chk(rq, "sample_win", sample_win, (opn >= 4 && cls < 10) ? 1 : 0);
        rq = late_load ? "R9" : ((sh > 9) ? "R8" : "R5");
        chk(rq, "sdo", sdo, data[9 - ((sh > 9) ? 9 : sh)]);
        chk("R4", "chan_valid", chan_valid, (cap >= 4) ? 1 : 0);
        if (cap >= 4) chk("R4", "chan_addr", chan_addr, addr);
        chk("R7", "eoc", eoc, eoc_model);
        rq = (cls > 10) ? "R8" : "R7";
        chk(rq, "start pulses", conv_cnt - starts, (cls >= 10) ? 1 : 0);
    endtask

    task automatic run_frame(input bit mp, input bit inv, input logic [3:0] addr,
                             input int nclk, input bit mid_load, input logic [9:0] mid_val);
        logic [9:0] data;
        int nr, nf, starts;
        bit late;
        data = res_model; nr = 0; nf = 0; starts = conv_cnt; late = 1'b0;
        fs = mp; edge_inv = inv; sclk = 1'b0;
        wait_clk(8);
        cs_n = 1'b0;
        wait_clk(8);
        chk("R4", "chan_valid at frame start", chan_valid, 0);
        if (mp) begin
            // R2: frame sync activity after the latch must not change the mode
            fs = 1'b0;
            wait_clk(8);
        end else begin
            chk("R3", "oe before fs fall", sdo_oe, 0);
            fs = 1'b1;
            wait_clk(8);
            chk("R2", "oe with fs high in DSP", sdo_oe, 0);
            fs = 1'b0;
            wait_clk(8);
        end
        chk("R3", "oe", sdo_oe, 1);
        chk("R3", "MSB", sdo, data[9]);
        for (int i = 1; i <= nclk; i++) begin
            sdi = (i <= 4) ? addr[4 - i] : 1'b0;
            if (mid_load && i == 3) begin
                conv_result = mid_val;
                conv_done = 1'b1;
                wait_clk(1);
                conv_done = 1'b0;
                res_model = mid_val;
                eoc_model = 1'b1;
                late = 1'b1;
            end
            wait_clk(8);
            sclk = 1'b1; nr++;
            wait_clk(8);
            check_state(mp, inv, addr, data, nr, nf, starts, late);
            sclk = 1'b0; nf++;
            wait_clk(8);
            check_state(mp, inv, addr, data, nr, nf, starts, late);
        end
        cs_n = 1'b1;
        fs = 1'b1;
        wait_clk(8);
        chk("R1", "oe after frame", sdo_oe, 0);
        chk("R11", "window after cs high", sample_win, 0);
        chk("R11", "frame start pulses", conv_cnt - starts, (nclk >= 10) ? 1 : 0);
        chk("R11", "eoc after frame", eoc, eoc_model);
    endtask

    task automatic t_idle();
        int starts;
        logic [3:0] a0;
        logic v0, e0;
        starts = conv_cnt; a0 = chan_addr; v0 = chan_valid; e0 = eoc;
        cs_n = 1'b1;
        for (int i = 0; i < 24; i++) begin
            sdi = i[1];
            sclk = ~sclk;
            wait_clk(4);
            if (sample_win !== 1'b0 || sdo_oe !== 1'b0)
                chk("R1", "idle window/oe", {sample_win, sdo_oe}, 0);
        end
        sclk = 1'b0;
        wait_clk(8);
        // R1
        chk("R1", "idle oe", sdo_oe, 0);
        chk("R1", "idle window", sample_win, 0);
        chk("R1", "idle addr", chan_addr, a0);
        chk("R1", "idle valid", chan_valid, v0);
        chk("R1", "idle eoc", eoc, e0);
        chk("R1", "idle start pulses", conv_cnt - starts, 0);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        run_frame(1'b1, 1'b1, 4'h9, 10, 1'b0, '0);
        t_load(10'h2B5);
        run_frame(1'b1, 1'b1, 4'hA, 12, 1'b0, '0);
        run_frame(1'b1, 1'b0, 4'h5, 10, 1'b1, 10'h0F3);
        t_load(10'h3C6);
        run_frame(1'b0, 1'b1, 4'h3, 16, 1'b0, '0);
        t_load(10'h155);
        run_frame(1'b0, 1'b0, 4'hC, 10, 1'b0, '0);
        t_load(10'h2AA);
        t_idle();
        run_frame(1'b1, 1'b1, 4'h6, 6, 1'b0, '0);
        run_frame(1'b0, 1'b1, 4'hE, 6, 1'b0, '0);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule